// File: doc/BRIEF.md
# Programmable Prescaled One-Shot Pulse Generator

This block is a synchronous monostable. An edge on an asynchronous trigger input moves the pulse output to its active level and starts a timer. When the programmed duration has elapsed, the output goes back to idle. The duration is the product of two settings. The first is a master period, given as a count of system clocks. The second is a ratio that steps by powers of eight.

A single 4-bit configuration code sets both the ratio and the output polarity. The lower half of the code range drives active-high pulses and the upper half drives active-low pulses. The ratio is mirrored about the code midpoint, so codes 0 and 15 give the shortest pulse and codes 7 and 8 give the longest. The trigger edge sense is a parameter (`TRIG_RISE`, rising edges by default). The trigger passes through a two-flop synchronizer before edge detection.

The controller has two states. `ST_IDLE` waits for a trigger edge. `ST_RUN` times the pulse. The transition FIRE (`ST_IDLE` to `ST_RUN`) is taken on a detected trigger edge, and it latches the code and the master period. The transition EXPIRE (`ST_RUN` to `ST_IDLE`) is taken in the cycle where the last master period of the last ratio step ends. A synchronous reset forces `ST_IDLE` from either state.

Top module: `os_pulse_gen`

## Requirements
- R1: While reset is held and after it is released, `busy_o` is 0 and `pulse_o` equals bit 3 of `code_i`.
- R2: With the default rising sense, if `trig_i` is first sampled high at clock edge n after being low, then `busy_o` and the active level appear after edge n+2 and not earlier.
- R3: The pulse stays active for exactly N x P clock cycles, where N is the ratio and P is the effective master period.
- R4: The code-to-ratio mapping is as follows. For codes 0 to 7, k equals the code. For codes 8 to 15, k equals 15 minus the code. The ratio is N = 2^(3k), so it ranges from 1 to 2^21.
- R5: Codes 0 to 7 (code bit 3 = 0) give an idle-low, active-high pulse. Codes 8 to 15 (code bit 3 = 1) give an idle-high, active-low pulse. While idle, the output level follows the live code.
- R6: A master period input of 0 is treated as 1.
- R7: Trigger edges that arrive while the pulse is active are ignored. They neither extend nor restart the pulse.
- R8: The code and the master period are captured at FIRE. Changing either one during a pulse changes neither that pulse's width nor its active level.
- R9: Asserting reset during a pulse ends the pulse. `busy_o` is 0 and `pulse_o` shows the idle level after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Asynchronous trigger |
| code_i | input | 4 | Ratio and polarity code |
| period_i | input | PERIOD_W | Master period in clocks (0 is read as 1) |
| pulse_o | output | 1 | One-shot output |
| busy_o | output | 1 | High while a pulse is being timed |

## Verification
Pulses are fired with codes from both halves of the range, so a wrong mirror or a wrong polarity shows up as a width or level mismatch. Master periods of 0, 1 and larger values are used, so the clamp and the period-times-ratio product can each be told apart from an off-by-one in either counter. Two further runs toggle the trigger during a pulse and change the code and period mid-pulse; each keeps the width of an undisturbed run only if the latch and non-retrigger rules hold. A long pulse is cut short by reset to cover the abort path. A behavioural model is compared against the outputs on every cycle.

// File: rtl/os_pkg.sv
package os_pkg;
    localparam int RATIO_SHIFT = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } os_state_e;
endpackage

// File: rtl/os_trig_sync.sv
module os_trig_sync #(
    parameter bit RISE   = 1'b1,
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    generate
        if (RISE) begin : g_rise
            assign edge_o = chain_q[STAGES-1] & ~last_q;
        end else begin : g_fall
            assign edge_o = ~chain_q[STAGES-1] & last_q;
        end
    endgenerate
endmodule

// File: rtl/os_cfg_decode.sv
module os_cfg_decode #(
    parameter int CODE_W = 4,
    parameter int DIV_W  = 21
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              pol_o,
    output logic [DIV_W-1:0]  term_o
);
    localparam int KW = CODE_W - 1;
    localparam int SW = $clog2(DIV_W + 1);

    logic [KW-1:0] k;
    logic [SW-1:0] span;

    always_comb begin
        pol_o = code_i[CODE_W-1];
        // upper half mirrors the lower half: 15-code == ~low bits
        k     = pol_o ? ~code_i[KW-1:0] : code_i[KW-1:0];
        span  = SW'(os_pkg::RATIO_SHIFT * int'(k));
    end

    // terminal count N-1 is a run of 3k ones from the LSB
    generate
        for (genvar g = 0; g < DIV_W; g++) begin : g_mask
            assign term_o[g] = (SW'(g) < span);
        end
    endgenerate
endmodule

// File: rtl/os_master_timer.sv
module os_master_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                run_i,
    input  logic [PERIOD_W-1:0] span_i,
    output logic                tick_o
);
    logic [PERIOD_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == (span_i - PERIOD_W'(1)));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PERIOD_W'(1);
        end
    end
endmodule

// File: rtl/os_ratio_counter.sv
module os_ratio_counter #(
    parameter int DIV_W = 21
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] term_i,
    output logic             done_o,
    output logic [DIV_W-1:0] count_o
);
    logic [DIV_W-1:0] cnt_q;

    assign done_o  = tick_i && (cnt_q == term_i);
    assign count_o = cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= done_o ? '0 : cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/os_pulse_gen.sv
module os_pulse_gen
    import os_pkg::*;
#(
    parameter int PERIOD_W    = 16,
    parameter bit TRIG_RISE   = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                trig_i,
    input  logic [3:0]          code_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                pulse_o,
    output logic                busy_o
);
    localparam int CODE_W = 4;
    localparam int MAX_K  = 2 ** (CODE_W - 1) - 1;
    localparam int DIV_W  = RATIO_SHIFT * MAX_K;

    os_state_e           state_q, state_d;
    logic                trig_edge;
    logic                fire, expire, tick, running;
    logic                live_pol, pol_q;
    logic [DIV_W-1:0]    live_term, term_q, div_cnt;
    logic [PERIOD_W-1:0] span_live, span_q;

    os_trig_sync #(
        .RISE   (TRIG_RISE),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (trig_i),
        .edge_o  (trig_edge)
    );

    os_cfg_decode #(
        .CODE_W (CODE_W),
        .DIV_W  (DIV_W)
    ) u_decode (
        .code_i (code_i),
        .pol_o  (live_pol),
        .term_o (live_term)
    );

    assign span_live = (period_i == '0) ? PERIOD_W'(1) : period_i;
    assign running   = (state_q == ST_RUN);

    os_master_timer #(
        .PERIOD_W (PERIOD_W)
    ) u_master (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (running),
        .span_i (span_q),
        .tick_o (tick)
    );

    os_ratio_counter #(
        .DIV_W (DIV_W)
    ) u_ratio (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (running),
        .tick_i  (tick),
        .term_i  (term_q),
        .done_o  (expire),
        .count_o (div_cnt)
    );

    // next-state logic: FIRE and EXPIRE
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_edge) begin
                    state_d = ST_RUN;
                    fire    = 1'b1;
                end
            end
            ST_RUN: begin
                if (expire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // configuration captured at FIRE only
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pol_q  <= 1'b0;
            term_q <= '0;
            span_q <= PERIOD_W'(1);
        end else if (fire) begin
            pol_q  <= live_pol;
            term_q <= live_term;
            span_q <= span_live;
        end
    end

    always_comb begin
        busy_o  = running;
        pulse_o = running ? ~pol_q : live_pol;
    end
endmodule

// File: rtl/os_pulse_gen_chk.sv
module os_pulse_gen_chk #(
    parameter int PERIOD_W = 16,
    parameter int DIV_W    = 21
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                trig_edge,
    input logic                busy_o,
    input logic                pulse_o,
    input logic                code_msb,
    input logic [PERIOD_W-1:0] span_q,
    input logic [DIV_W-1:0]    div_cnt,
    input logic [DIV_W-1:0]    term_q
);
    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (pulse_o == code_msb)); // R5
    AST_ACTIVE_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> (pulse_o == !$past(code_msb))); // R5
    AST_HOLD_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && $past(busy_o)) |-> $stable(pulse_o)); // R8
    AST_FIRE_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> $past(trig_edge)); // R2
    AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> (div_cnt <= term_q)); // R4
    AST_PERIOD_CLAMP: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> (span_q != '0)); // R6
    AST_NO_RETRIG: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && trig_edge && (div_cnt != term_q)) |=> busy_o); // R7
endmodule

bind os_pulse_gen os_pulse_gen_chk #(
    .PERIOD_W (PERIOD_W),
    .DIV_W    (DIV_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .trig_edge (trig_edge),
    .busy_o    (busy_o),
    .pulse_o   (pulse_o),
    .code_msb  (code_i[3]),
    .span_q    (span_q),
    .div_cnt   (div_cnt),
    .term_q    (term_q)
);

// File: tb/os_pulse_gen_tb.sv
module os_pulse_gen_tb;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic [3:0]    code = 4'd9;
    logic [PW-1:0] period = PW'(1);
    logic          pulse, busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit started = 1'b0;

    always #10 clk = ~clk;

    os_pulse_gen #(.PERIOD_W(PW), .TRIG_RISE(1'b1), .SYNC_STAGES(2)) u_dut (
        .clk_i(clk), .rst_i(rst), .trig_i(trig), .code_i(code),
        .period_i(period), .pulse_o(pulse), .busy_o(busy)
    );

    function automatic longint ref_width(input logic [3:0] c, input logic [PW-1:0] p);
        int k;
        longint n;
        k = (c < 4'd8) ? int'(c) : 15 - int'(c);
        n = longint'(1) << (3 * k);
        return n * ((p == '0) ? longint'(1) : longint'(p));
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_s1, m_s2, m_prev, m_act, m_pol;
    longint m_rem;
    always @(posedge clk) begin
        bit e;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_act = 0; m_rem = 0;
            started = 1'b1;
        end else begin
            e = m_s2 && !m_prev;
            if (m_act) begin
                m_rem--;
                if (m_rem == 0) m_act = 0;
            end else if (e) begin
                m_act = 1;
                m_rem = ref_width(code, period);
                m_pol = code[3];
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = trig;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            bit exp_pulse;
            exp_pulse = m_act ? !m_pol : code[3];
            check(busy == m_act, "R3 R7 busy per-cycle", longint'(busy), longint'(m_act));
            check(pulse == exp_pulse, "R5 R8 pulse per-cycle", longint'(pulse), longint'(exp_pulse));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic run_pulse(input logic [3:0] c, input logic [PW-1:0] p,
                             input bit retrig, input bit mutate, input string tag);
        longint w;
        longint cnt;
        w = ref_width(c, p);
        step(); code = c; period = p;
        step(); trig = 1'b1;                       // first sampled at edge n
        @(negedge clk); check(busy == 1'b0, {tag, " R2 not after n"}, longint'(busy), 0);
        @(negedge clk); check(busy == 1'b0, {tag, " R2 not after n+1"}, longint'(busy), 0);
        @(negedge clk); check(busy == 1'b1, {tag, " R2 after n+2"}, longint'(busy), 1);
        check(pulse == !c[3], {tag, " R5 active level"}, longint'(pulse), longint'(!c[3]));
        #2 trig = 1'b0;
        cnt = 1;
        forever begin
            @(negedge clk);
            if (!busy) break;
            cnt++;
            if (cnt > w + 8) break;
            #2;
            if (retrig && (cnt % 4 == 0) && (cnt < w - 8)) trig = ~trig;
            if (mutate && cnt == 5) begin
                code = ~c;
                period = p + PW'(3);
            end
        end
        check(cnt == w, {tag, " R3 width"}, cnt, w);
        #2 trig = 1'b0;
        repeat (4) step();
    endtask

    initial begin
        repeat (3) step();
        check(busy == 1'b0, "R1 busy in reset", longint'(busy), 0);
        check(pulse == 1'b1, "R1 idle level in reset code 9", longint'(pulse), 1);
        rst = 1'b0;
        step();
        check(busy == 1'b0, "R1 busy after reset", longint'(busy), 0);
        code = 4'd2;
        step();
        check(pulse == 1'b0, "R1 R5 idle follows live code", longint'(pulse), 0);

        run_pulse(4'd0,  PW'(3), 0, 0, "R4 code0");
        run_pulse(4'd1,  PW'(2), 0, 0, "R4 code1");
        run_pulse(4'd2,  PW'(1), 0, 0, "R4 code2");
        run_pulse(4'd3,  PW'(1), 0, 0, "R4 code3");
        run_pulse(4'd4,  PW'(1), 0, 0, "R4 code4");
        run_pulse(4'd5,  PW'(1), 0, 0, "R4 code5");
        run_pulse(4'd15, PW'(4), 0, 0, "R4 R5 code15");
        run_pulse(4'd14, PW'(3), 0, 0, "R4 R5 code14");
        run_pulse(4'd13, PW'(1), 0, 0, "R4 R5 code13");
        run_pulse(4'd12, PW'(2), 0, 0, "R4 R5 code12");
        run_pulse(4'd11, PW'(1), 0, 0, "R4 R5 code11");
        run_pulse(4'd1,  PW'(0), 0, 0, "R6 period zero");
        run_pulse(4'd14, PW'(0), 0, 0, "R6 period zero inv");
        run_pulse(4'd2,  PW'(1), 1, 0, "R7 retrigger");
        run_pulse(4'd13, PW'(2), 1, 0, "R7 retrigger inv");
        run_pulse(4'd2,  PW'(2), 0, 1, "R8 mutate");
        run_pulse(4'd14, PW'(5), 0, 1, "R8 mutate inv");

        // R9: abort a long pulse with reset
        step(); code = 4'd7; period = PW'(1);
        step(); trig = 1'b1;
        repeat (100) step();
        check(busy == 1'b1, "R9 long pulse running", longint'(busy), 1);
        trig = 1'b0;
        rst = 1'b1;
        step();
        check(busy == 1'b0, "R9 busy after reset", longint'(busy), 0);
        check(pulse == 1'b0, "R9 idle level after reset", longint'(pulse), 0);
        rst = 1'b0;
        repeat (4) step();
        check(busy == 1'b0, "R9 stays idle", longint'(busy), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule